// File: doc/BRIEF.md
# Double-Buffered Strobed Input Port

This block is the receive side of a parallel peripheral port. An external device places a byte on the port pins and asserts a strobe pin. The block synchronizes that strobe, detects its asserted edge and captures the byte into a two-stage holding buffer. Software then reads the bytes in arrival order through a single data register. A status flag shows whether unread data is waiting. An optional request output lets a DMA engine empty the buffer without software polling.

A second, companion handshake pin can take one of five programmable roles. It can be a ready output that follows the buffer state, either interlocked or as a pulse of limited length. It can be an output fixed at its negated or its asserted level. It can also be an edge-sensitive input that sets its own status flag. A sense bit for each pin selects whether that pin is active high or active low. A port enable clears the whole block when it is low.

Top module: `hsk_in_port`

## Requirements
- R1: After reset, with `port_en` low, `stat_strobe`, `stat_comp` and `dma_req` are 0. With both sense bits at 0 (pins active low), `comp_pin_out` sits at its negated level of 1.
- R2: An asserted edge on `strobe_pin` (asserted level = `strobe_pin` XNOR `strobe_sense`) captures `pins_in`. The byte is presented on `rd_data` within four clocks of the pin edge. `stat_strobe` is 1 while at least one captured byte has not yet been read, and returns to 0 after the last byte is read through `rd_stb`.
- R3: Two captured bytes are read back in capture order. A read takes the byte in the final stage, and the byte in the initial stage moves forward on the following clock.
- R4: When both stages hold data, a further asserted strobe edge is dropped, and the buffered bytes are kept unchanged.
- R5: When `comp_role` = 3 (interlocked), the companion pin is asserted while the buffer has room. It is negated for the clock after a captured strobe edge and asserted again on the next clock if room exists. While both stages are full it stays negated until a read frees a stage.
- R6: In the interlocked and pulsed roles, a strobe edge that arrives while the ready window is closed captures nothing.
- R7: When `comp_role` = 4 (pulsed), the companion pin asserts under the same conditions as in the interlocked role, but for no more than PULSE_CLKS (4) consecutive clocks. The ready window stays open after the pulse ends, so a strobe edge arriving later is still captured.
- R8: When `comp_role` = 0, `comp_pin_oe` is 0 and an asserted edge on `comp_pin_in` sets `stat_comp`. A `stat_wr` with bit 1 of `stat_wdata` set clears `stat_comp`. A write with bit 1 clear leaves it set. Bit 0 (the strobe flag) is never cleared by a write.
- R9: `comp_role` = 1 holds the companion pin negated and `comp_role` = 2 holds it asserted, both with `comp_pin_oe` = 1. In these two roles `stat_comp` reads 0 whatever happens on `comp_pin_in`. Codes 5 to 7 act like code 1.
- R10: A sense bit of 1 makes its pin active high. The strobe then captures on a rising pin edge, and an asserted companion output drives 1.
- R11: With `dma_en` high, each byte that enters the final stage raises `dma_req` for exactly DMA_CLKS (3) consecutive clocks. With `dma_en` low, `dma_req` stays 0.
- R12: While `port_en` is low, the buffer is emptied and the status flags are held at 0. The companion pin is negated and strobe edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port enable; low clears buffer, flags and ready state |
| comp_role | input | 3 | Companion pin role: 0 edge input, 1 fixed negated, 2 fixed asserted, 3 interlocked ready, 4 pulsed ready |
| strobe_sense | input | 1 | Strobe pin polarity, 1 = active high |
| comp_sense | input | 1 | Companion pin polarity, 1 = active high |
| dma_en | input | 1 | Enables the DMA request pulse |
| pins_in | input | DW | Port data pins |
| strobe_pin | input | 1 | Raw strobe pin from the peripheral |
| comp_pin_in | input | 1 | Raw companion pin level, used in role 0 |
| comp_pin_out | output | 1 | Companion pin output level |
| comp_pin_oe | output | 1 | Companion pin output enable |
| rd_stb | input | 1 | One-clock read of the data register |
| rd_data | output | DW | Data register (final buffer stage) |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 2 | Write-one-to-clear mask: bit 1 companion flag, bit 0 strobe flag |
| stat_strobe | output | 1 | Unread data present |
| stat_comp | output | 1 | Companion edge flag |
| dma_req | output | 1 | DMA request pulse, active high |

## Verification
The properties assume that `comp_role`, the sense bits and `port_en` change only when the buffer state cannot be affected between clocks. The properties also assume that the raw pins are quasi-static relative to the clock, so the two-flop synchronizer sees each level for several cycles. The stimulus changes role and polarity only while the port is disabled, and lets the pins settle before enabling it again. It holds every pin level for four clocks and keeps `pins_in` stable around each strobe edge. `rd_stb` and `stat_wr` are driven for single clocks, apart from any strobe activity.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    typedef enum logic [2:0] {
        ROLE_EDGE_IN = 3'd0,
        ROLE_OUT_NEG = 3'd1,
        ROLE_OUT_ASR = 3'd2,
        ROLE_INTLK   = 3'd3,
        ROLE_PULSE   = 3'd4
    } comp_role_e;

    localparam int STAT_W          = 2;
    localparam int STAT_BIT_STROBE = 0;
    localparam int STAT_BIT_COMP   = 1;

    function automatic logic role_is_handshake(input logic [2:0] r);
        return (r == ROLE_INTLK) || (r == ROLE_PULSE);
    endfunction

endpackage

// File: rtl/hsk_edge_sync.sv
module hsk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sense,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;
    logic  raw_act;

    always_comb begin
        // asserted level: pin equals the sense bit
        raw_act = ~(pin ^ sense);
        st_d    = st_q;
        st_d.sh[0] = raw_act;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sh[i] = st_q.sh[i-1];
        end
        st_d.prev = st_q.sh[STAGES-1];
        rise      = st_q.sh[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsk_dbuf.sv
module hsk_dbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic          any,
    output logic          fin_valid,
    output logic [DW-1:0] fin_data
);
    typedef struct packed {
        logic          ini_v;
        logic [DW-1:0] ini_d;
        logic          fin_v;
        logic [DW-1:0] fin_d;
    } buf_t;

    buf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop && st_q.fin_v) begin
            st_d.fin_v = 1'b0;
        end
        // initial stage advances only into an already empty final stage
        if (st_q.ini_v && !st_q.fin_v) begin
            st_d.fin_v = 1'b1;
            st_d.fin_d = st_q.ini_d;
            st_d.ini_v = 1'b0;
        end
        if (push && !(st_q.ini_v && st_q.fin_v)) begin
            st_d.ini_v = 1'b1;
            st_d.ini_d = push_data;
        end
        if (clear) begin
            st_d.ini_v = 1'b0;
            st_d.fin_v = 1'b0;
        end
        full      = st_q.ini_v & st_q.fin_v;
        any       = st_q.ini_v | st_q.fin_v;
        fin_valid = st_q.fin_v;
        fin_data  = st_q.fin_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsk_ready_ctl.sv
module hsk_ready_ctl
    import hsk_pkg::*;
#(
    parameter int PULSE_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [2:0] role,
    input  logic       strobe_rise,
    input  logic       buf_full,
    input  logic       comp_rise,
    input  logic       clr_comp,
    output logic       capture,
    output logic       comp_act,
    output logic       comp_oe,
    output logic       comp_stat
);
    localparam int PW = $clog2(PULSE_CLKS + 1);
    localparam logic [PW-1:0] PLIM = PW'(PULSE_CLKS);

    typedef struct packed {
        logic          rdy;
        logic [PW-1:0] pcnt;
        logic          cstat;
    } rdy_t;

    rdy_t st_d, st_q;
    logic hs;
    logic window;

    always_comb begin
        hs      = role_is_handshake(role);
        window  = hs ? st_q.rdy : 1'b1;
        capture = enable & strobe_rise & ~buf_full & window;
        st_d    = st_q;

        if (!enable || !hs) begin
            st_d.rdy  = 1'b0;
            st_d.pcnt = '0;
        end else if (capture) begin
            st_d.rdy  = 1'b0;
            st_d.pcnt = '0;
        end else if (!st_q.rdy) begin
            if (!buf_full) begin
                st_d.rdy  = 1'b1;
                st_d.pcnt = '0;
            end
        end else if (role == ROLE_PULSE && st_q.pcnt != PLIM) begin
            st_d.pcnt = st_q.pcnt + 1'b1;
        end

        if (!enable || role != ROLE_EDGE_IN) begin
            st_d.cstat = 1'b0;
        end else begin
            if (clr_comp)  st_d.cstat = 1'b0;
            if (comp_rise) st_d.cstat = 1'b1;
        end

        case (role)
            ROLE_OUT_ASR: comp_act = enable;
            ROLE_INTLK:   comp_act = st_q.rdy;
            ROLE_PULSE:   comp_act = st_q.rdy && (st_q.pcnt < PLIM);
            default:      comp_act = 1'b0;
        endcase
        comp_oe   = (role != ROLE_EDGE_IN);
        comp_stat = st_q.cstat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsk_dma_pulse.sv
module hsk_dma_pulse #(
    parameter int CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic fin_valid,
    output logic req
);
    localparam int CW = $clog2(CLKS + 1);
    localparam logic [CW-1:0] CLIM = CW'(CLKS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          prev;
    } dma_t;

    dma_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = fin_valid;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (fin_valid && !st_q.prev) begin
            st_d.cnt = CLIM;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        req = (st_q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hsk_in_port.sv
module hsk_in_port
    import hsk_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_CLKS  = 4,
    parameter int DMA_CLKS    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_en,
    input  logic [2:0]    comp_role,
    input  logic          strobe_sense,
    input  logic          comp_sense,
    input  logic          dma_en,
    input  logic [DW-1:0] pins_in,
    input  logic          strobe_pin,
    input  logic          comp_pin_in,
    output logic          comp_pin_out,
    output logic          comp_pin_oe,
    input  logic          rd_stb,
    output logic [DW-1:0] rd_data,
    input  logic          stat_wr,
    input  logic [1:0]    stat_wdata,
    output logic          stat_strobe,
    output logic          stat_comp,
    output logic          dma_req
);
    logic strobe_rise, comp_rise;
    logic capture, buf_full, buf_any, fin_valid;
    logic comp_act, clr_comp;

    assign clr_comp = stat_wr & stat_wdata[STAT_BIT_COMP];

    hsk_edge_sync #(.STAGES(SYNC_STAGES)) i_strobe_sync (
        .clk(clk), .rst_n(rst_n), .pin(strobe_pin), .sense(strobe_sense),
        .rise(strobe_rise)
    );

    hsk_edge_sync #(.STAGES(SYNC_STAGES)) i_comp_sync (
        .clk(clk), .rst_n(rst_n), .pin(comp_pin_in), .sense(comp_sense),
        .rise(comp_rise)
    );

    hsk_dbuf #(.DW(DW)) i_dbuf (
        .clk(clk), .rst_n(rst_n), .clear(~port_en), .push(capture),
        .push_data(pins_in), .pop(rd_stb), .full(buf_full), .any(buf_any),
        .fin_valid(fin_valid), .fin_data(rd_data)
    );

    hsk_ready_ctl #(.PULSE_CLKS(PULSE_CLKS)) i_ready (
        .clk(clk), .rst_n(rst_n), .enable(port_en), .role(comp_role),
        .strobe_rise(strobe_rise), .buf_full(buf_full), .comp_rise(comp_rise),
        .clr_comp(clr_comp), .capture(capture), .comp_act(comp_act),
        .comp_oe(comp_pin_oe), .comp_stat(stat_comp)
    );

    hsk_dma_pulse #(.CLKS(DMA_CLKS)) i_dma (
        .clk(clk), .rst_n(rst_n), .enable(dma_en & port_en),
        .fin_valid(fin_valid), .req(dma_req)
    );

    always_comb begin
        comp_pin_out = ~(comp_act ^ comp_sense);
        stat_strobe  = buf_any;
    end
endmodule

// File: rtl/hsk_in_port_chk.sv
module hsk_in_port_chk
    import hsk_pkg::*;
#(
    parameter int PULSE_CLKS = 4,
    parameter int DMA_CLKS   = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       port_en,
    input logic [2:0] comp_role,
    input logic       comp_sense,
    input logic       comp_pin_out,
    input logic       stat_strobe,
    input logic       stat_comp,
    input logic       dma_en,
    input logic       dma_req,
    input logic       buf_full
);
    logic       comp_on;
    logic [7:0] dma_run_q, pul_run_q;

    assign comp_on = ~(comp_pin_out ^ comp_sense);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_run_q <= '0;
            pul_run_q <= '0;
        end else begin
            dma_run_q <= !dma_req ? 8'd0 : (dma_run_q == 8'hFF ? dma_run_q : dma_run_q + 8'd1);
            pul_run_q <= (comp_role != ROLE_PULSE || !comp_on) ? 8'd0
                       : (pul_run_q == 8'hFF ? pul_run_q : pul_run_q + 8'd1);
        end
    end

    // R5
    intlk_full_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_role == ROLE_INTLK && buf_full) |-> !comp_on);

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_role == ROLE_PULSE && comp_on) |-> (pul_run_q < 8'(PULSE_CLKS)));

    // R9
    fixed_no_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_role == ROLE_OUT_NEG || comp_role == ROLE_OUT_ASR) |=> !stat_comp);

    // R11
    dma_max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (dma_run_q < 8'(DMA_CLKS)));

    // R11
    dma_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dma_req) && DMA_CLKS > 1) |=> dma_req);

    // R11
    dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !dma_req);

    // R12
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!stat_strobe && !stat_comp && !dma_req));
endmodule

bind hsk_in_port hsk_in_port_chk #(
    .PULSE_CLKS(PULSE_CLKS),
    .DMA_CLKS(DMA_CLKS)
) i_chk (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .comp_role(comp_role),
    .comp_sense(comp_sense), .comp_pin_out(comp_pin_out),
    .stat_strobe(stat_strobe), .stat_comp(stat_comp), .dma_en(dma_en),
    .dma_req(dma_req), .buf_full(buf_full)
);

// File: tb/test_hsk_in_port.sv
module test_hsk_in_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic [2:0] comp_role = 3'd3;
    logic       strobe_sense = 1'b0, comp_sense = 1'b0, dma_en = 1'b0;
    logic [7:0] pins_in = 8'h00;
    logic       strobe_pin = 1'b1, comp_pin_in = 1'b1;
    logic       comp_pin_out, comp_pin_oe;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       stat_wr = 1'b0;
    logic [1:0] stat_wdata = 2'b00;
    logic       stat_strobe, stat_comp, dma_req;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    bit dma_win = 1'b0, dma_prev = 1'b0;
    int dma_hi = 0, dma_rises = 0;

    always #10 clk = ~clk;

    hsk_in_port i_hsk_in_port (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .comp_role(comp_role),
        .strobe_sense(strobe_sense), .comp_sense(comp_sense), .dma_en(dma_en),
        .pins_in(pins_in), .strobe_pin(strobe_pin), .comp_pin_in(comp_pin_in),
        .comp_pin_out(comp_pin_out), .comp_pin_oe(comp_pin_oe), .rd_stb(rd_stb),
        .rd_data(rd_data), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat_strobe(stat_strobe), .stat_comp(stat_comp), .dma_req(dma_req)
    );

    always @(negedge clk) begin
        if (dma_win) begin
            if (dma_req) dma_hi++;
            if (dma_req && !dma_prev) dma_rises++;
            dma_prev = dma_req;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] d);
        pins_in = d;
        strobe_pin = strobe_sense;
        tick(4);
        strobe_pin = ~strobe_sense;
        tick(4);
    endtask

    task automatic comp_edge();
        comp_pin_in = comp_sense;
        tick(4);
        comp_pin_in = ~comp_sense;
        tick(4);
    endtask

    task automatic read_reg(output logic [7:0] d);
        rd_stb = 1'b1;
        #1 d = rd_data;
        tick(1);
        rd_stb = 1'b0;
        tick(2);
    endtask

    task automatic stat_write(input logic [1:0] m);
        stat_wr = 1'b1;
        stat_wdata = m;
        tick(1);
        stat_wr = 1'b0;
        tick(1);
    endtask

    task automatic reconfig(input logic [2:0] r);
        port_en = 1'b0;
        tick(2);
        comp_role = r;
        port_en = 1'b1;
        tick(3);
    endtask

    task automatic t_reset();
        check("R1 strobe flag", 32'(stat_strobe), 32'd0);
        check("R1 comp flag", 32'(stat_comp), 32'd0);
        check("R1 dma", 32'(dma_req), 32'd0);
        check("R1 comp pin negated", 32'(comp_pin_out), 32'd1);
    endtask

    task automatic t_capture();
        logic [7:0] d;
        reconfig(3'd1);
        strobe(8'hA5);
        check("R2 flag set", 32'(stat_strobe), 32'd1);
        read_reg(d);
        check("R2 data", 32'(d), 32'hA5);
        check("R2 flag clear", 32'(stat_strobe), 32'd0);
    endtask

    task automatic t_order_full();
        logic [7:0] d;
        reconfig(3'd0);
        strobe(8'h31);
        strobe(8'h32);
        strobe(8'h33);
        read_reg(d);
        check("R3 first", 32'(d), 32'h31);
        check("R3 flag still set", 32'(stat_strobe), 32'd1);
        read_reg(d);
        check("R3 second", 32'(d), 32'h32);
        check("R4 third dropped", 32'(stat_strobe), 32'd0);
    endtask

    task automatic t_interlock();
        logic [7:0] d;
        reconfig(3'd3);
        check("R5 ready asserted", 32'(comp_pin_out), 32'd0);
        pins_in = 8'h5C;
        strobe_pin = 1'b0;
        tick(3);
        check("R5 negated after edge", 32'(comp_pin_out), 32'd1);
        tick(1);
        check("R5 reasserted", 32'(comp_pin_out), 32'd0);
        tick(1);
        strobe_pin = 1'b1;
        tick(4);
        strobe(8'h6D);
        check("R5 negated when full", 32'(comp_pin_out), 32'd1);
        strobe(8'h7E);
        check("R5 still negated", 32'(comp_pin_out), 32'd1);
        read_reg(d);
        check("R3 interlock first", 32'(d), 32'h5C);
        check("R5 asserted after read", 32'(comp_pin_out), 32'd0);
        read_reg(d);
        check("R3 interlock second", 32'(d), 32'h6D);
        check("R6 closed-window edge ignored", 32'(stat_strobe), 32'd0);
    endtask

    task automatic t_pulsed();
        logic [7:0] d;
        int on = 0;
        port_en = 1'b0;
        tick(2);
        comp_role = 3'd4;
        port_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            if (comp_pin_out == 1'b0) on++;
        end
        check("R7 pulse length", 32'(on), 32'd4);
        check("R7 negated after pulse", 32'(comp_pin_out), 32'd1);
        strobe(8'h5A);
        check("R7 late edge captured", 32'(stat_strobe), 32'd1);
        read_reg(d);
        check("R7 late data", 32'(d), 32'h5A);
    endtask

    task automatic t_edge_in();
        reconfig(3'd0);
        check("R8 oe off", 32'(comp_pin_oe), 32'd0);
        comp_edge();
        check("R8 flag set", 32'(stat_comp), 32'd1);
        stat_write(2'b01);
        check("R8 bit0 write ignored", 32'(stat_comp), 32'd1);
        stat_write(2'b00);
        check("R8 zero write ignored", 32'(stat_comp), 32'd1);
        stat_write(2'b10);
        check("R8 cleared", 32'(stat_comp), 32'd0);
    endtask

    task automatic t_fixed();
        reconfig(3'd2);
        check("R9 fixed asserted", 32'(comp_pin_out), 32'd0);
        check("R9 oe on", 32'(comp_pin_oe), 32'd1);
        comp_edge();
        check("R9 flag zero", 32'(stat_comp), 32'd0);
        reconfig(3'd1);
        check("R9 fixed negated", 32'(comp_pin_out), 32'd1);
        reconfig(3'd6);
        check("R9 spare code negated", 32'(comp_pin_out), 32'd1);
    endtask

    task automatic t_sense();
        logic [7:0] d;
        port_en = 1'b0;
        strobe_sense = 1'b1;
        comp_sense = 1'b1;
        strobe_pin = 1'b0;
        comp_pin_in = 1'b0;
        tick(4);
        comp_role = 3'd2;
        port_en = 1'b1;
        tick(2);
        check("R10 active-high comp", 32'(comp_pin_out), 32'd1);
        strobe(8'hC3);
        read_reg(d);
        check("R10 rising edge capture", 32'(d), 32'hC3);
        port_en = 1'b0;
        strobe_sense = 1'b0;
        comp_sense = 1'b0;
        strobe_pin = 1'b1;
        comp_pin_in = 1'b1;
        tick(4);
    endtask

    task automatic t_dma();
        logic [7:0] d;
        reconfig(3'd1);
        dma_en = 1'b1;
        dma_win = 1'b1;
        strobe(8'h01);
        strobe(8'h02);
        read_reg(d);
        tick(6);
        read_reg(d);
        tick(6);
        check("R11 pulse count", 32'(dma_rises), 32'd2);
        check("R11 high clocks", 32'(dma_hi), 32'd6);
        dma_en = 1'b0;
        strobe(8'h03);
        read_reg(d);
        tick(4);
        check("R11 disabled", 32'(dma_hi), 32'd6);
        dma_win = 1'b0;
    endtask

    task automatic t_disable();
        reconfig(3'd3);
        strobe(8'h44);
        strobe(8'h55);
        port_en = 1'b0;
        tick(1);
        check("R12 comp negated", 32'(comp_pin_out), 32'd1);
        check("R12 flushed", 32'(stat_strobe), 32'd0);
        strobe(8'h66);
        port_en = 1'b1;
        tick(2);
        check("R12 edge ignored", 32'(stat_strobe), 32'd0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_capture();
        t_order_full();
        t_interlock();
        t_pulsed();
        t_edge_in();
        t_fixed();
        t_sense();
        t_dma();
        t_disable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule